// File: doc/BRIEF.md
# Write-Combining Store Buffer with Ordered Drain

This block sits between a core's store path and a memory port. Each request carries an operation kind, a memory type and a non-temporal flag. Stores to write-combining memory, and non-temporal stores of any memory type, are gathered into line-sized entries with per-byte enables. An entry goes to memory later, as one full-line transfer, when it is evicted. Loads from write-combining memory go straight to memory and never look in the buffer, so they can return old data while a matching store is still held.

Fences, locked operations, interrupts and every uncached read or write first force all held entries out to memory, oldest first. Only then is the request accepted or the uncached access issued. Uncached stores use the same memory port as single, unmerged transfers. Write-back traffic belongs to the cache path: it is accepted at once and causes no memory transfer and no drain. The requester sees a busy flag while any entry is held, and a one-cycle pulse after each barrier completes.

Top module: `wcomb_buffer`

## Requirements
- R1: After synchronous reset the buffer holds nothing: `busy` is 0, `drain_done` is 0 and `mem_valid` is 0 while no request is presented.
- R2: Request kinds are encoded on `req_kind` as store=0, load=1, store-fence=2, full-fence=3, locked op=4, interrupt=5. Memory types are encoded on `req_mtype` as write-back=0, write-combining=1, uncached=2. A store to write-combining memory merges into the held entry for the same 64-byte line, or allocates a new entry. Byte enables are OR-ed together and later bytes overwrite earlier ones. It produces no memory transfer until that entry is evicted.
- R3: A store with `req_nt`=1 is buffered exactly like a write-combining store, whatever its memory type. It causes no memory transfer and no drain when it is accepted.
- R4: A load to write-combining memory is issued at once on the memory port as a read (`mem_cmd`=2) with its own address, without draining held entries.
- R5: An uncached load or store is issued only after every held entry has been written out. An uncached store is one transfer (`mem_cmd`=1) whose `mem_be` marks the store's bytes at lane offset 8×(word index within the line). It is never merged.
- R6: A store-fence or full-fence is accepted only when the buffer is empty. `drain_done` pulses high in the cycle after the fence is accepted.
- R7: A locked operation or an interrupt drains the buffer the same way and also pulses `drain_done` after acceptance.
- R8: Write-back loads and stores (with `req_nt`=0) are accepted without any memory transfer and without draining.
- R9: When all four entries are held and a write-combining store needs a new line, exactly the oldest entry is written out before the store is accepted.
- R10: Each evicted entry is one transfer (`mem_cmd`=0) with a line-aligned address. Entries leave in the order they were allocated.
- R11: While `mem_valid` is high and `mem_ready` is low, the transfer stays offered with unchanged command and address.
- R12: `busy` is high exactly while at least one entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_kind | input | 3 | Operation kind (see R2) |
| req_mtype | input | 2 | Memory type of the address (see R2) |
| req_nt | input | 1 | Non-temporal hint |
| req_addr | input | ADDR_W | Byte address (word aligned) |
| req_wdata | input | WORD_BYTES*8 | Store data |
| req_be | input | WORD_BYTES | Store byte enables |
| mem_valid | output | 1 | Memory transfer offered |
| mem_ready | input | 1 | Memory accepts the transfer |
| mem_cmd | output | 2 | 0 line write, 1 uncached write, 2 read |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | LINE_BYTES*8 | Line-wide write data |
| mem_be | output | LINE_BYTES | Line-wide byte enables |
| busy | output | 1 | At least one entry held |
| drain_done | output | 1 | Pulse one cycle after a barrier is accepted |

## Verification
Corrupted entry state shows up at the memory port. A wrong merge or a lost byte enable changes the byte image that memory holds after the next fence. A wrong age pointer makes line writes leave out of order, or evicts the wrong line when the buffer overflows. Either error is visible within the cycles of that drain. A bad occupancy count shows at once on `busy`, and also as a fence that is accepted while data is still held, or one that never completes. The bench keeps a byte image of memory built from observed transfers. It compares that image against program-order stores after each fence, under random stalls of the memory port.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_WORD_BYTES = 8;
    localparam int DEF_LINE_BYTES = 64;
    localparam int DEF_ENTRIES    = 4;

    typedef enum logic [2:0] {
        K_STORE  = 3'd0,
        K_LOAD   = 3'd1,
        K_SFENCE = 3'd2,
        K_MFENCE = 3'd3,
        K_LOCK   = 3'd4,
        K_INTR   = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        MT_WB = 2'd0,
        MT_WC = 2'd1,
        MT_UC = 2'd2
    } mtype_e;

    typedef enum logic [1:0] {
        MC_LINE_WR = 2'd0,
        MC_UC_WR   = 2'd1,
        MC_READ    = 2'd2
    } mcmd_e;

    // How a request is handled
    typedef enum logic [2:0] {
        RT_ABSORB,    // handled by the cache path, nothing to do here
        RT_COMBINE,   // merge into a line entry
        RT_READ_NOW,  // combining-memory read, bypasses held entries
        RT_UC_READ,   // uncached read after a full drain
        RT_UC_WRITE,  // uncached write after a full drain
        RT_BARRIER    // fence, lock or interrupt: accept once empty
    } route_e;

    function automatic route_e classify(logic [2:0] kind, logic [1:0] mtype, logic nt);
        route_e r;
        case (kind)
            K_STORE: begin
                if (nt || mtype == MT_WC) r = RT_COMBINE;
                else if (mtype == MT_WB)  r = RT_ABSORB;
                else                      r = RT_UC_WRITE;
            end
            K_LOAD: begin
                if (mtype == MT_WB)      r = RT_ABSORB;
                else if (mtype == MT_WC) r = RT_READ_NOW;
                else                     r = RT_UC_READ;
            end
            K_SFENCE, K_MFENCE, K_LOCK, K_INTR: r = RT_BARRIER;
            default: r = RT_ABSORB;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wcb_order.sv
// Allocation-order ring: oldest entry at head, next free slot at tail.
module wcb_order #(
    parameter int ENTRIES = 4,
    localparam int PTR_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] head_q;
    logic [CNT_W:0]   sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            head_q  <= '0;
        end else begin
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
            if (pop) begin
                head_q <= (head_q == PTR_W'(ENTRIES - 1)) ? '0 : head_q + 1'b1;
            end
        end
    end

    always_comb begin
        sum   = (CNT_W + 1)'(head_q) + (CNT_W + 1)'(count_q);
        tail  = (sum >= (CNT_W + 1)'(ENTRIES)) ? PTR_W'(sum - (CNT_W + 1)'(ENTRIES))
                                               : PTR_W'(sum);
        head  = head_q;
        full  = (count_q == CNT_W'(ENTRIES));
        empty = (count_q == '0);
    end

endmodule

// File: rtl/wcb_lines.sv
// Line storage: tag, data and byte enables per entry, with tag lookup and byte merge.
module wcb_lines #(
    parameter int ENTRIES    = 4,
    parameter int TAG_W      = 26,
    parameter int LINE_BYTES = 64,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic [ENTRIES-1:0]    hit,
    input  logic                  wr_en,
    input  logic                  wr_alloc,
    input  logic [PTR_W-1:0]      wr_slot,
    input  logic [LINE_W-1:0]     wr_data,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic                  clr_en,
    input  logic [PTR_W-1:0]      clr_slot,
    input  logic [PTR_W-1:0]      rd_slot,
    output logic [TAG_W-1:0]      rd_tag,
    output logic [LINE_W-1:0]     rd_data,
    output logic [LINE_BYTES-1:0] rd_be
);

    logic [ENTRIES-1:0][TAG_W-1:0]      tag_v;
    logic [ENTRIES-1:0][LINE_W-1:0]     data_v;
    logic [ENTRIES-1:0][LINE_BYTES-1:0] be_v;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic                  vld_r;
        logic [TAG_W-1:0]      tag_r;
        logic [LINE_W-1:0]     data_r;
        logic [LINE_BYTES-1:0] be_r;
        logic [LINE_W-1:0]     merged;
        logic                  sel_wr;

        assign sel_wr = wr_en && (wr_slot == PTR_W'(e));

        always_comb begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : data_r[b*8 +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_r <= 1'b0;
            end else if (sel_wr) begin
                vld_r <= 1'b1;
            end else if (clr_en && clr_slot == PTR_W'(e)) begin
                vld_r <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_wr) begin
                tag_r  <= lk_tag;
                data_r <= wr_alloc ? wr_data : merged;
                be_r   <= wr_alloc ? wr_be : (be_r | wr_be);
            end
        end

        assign hit[e]    = vld_r && (tag_r == lk_tag);
        assign tag_v[e]  = tag_r;
        assign data_v[e] = data_r;
        assign be_v[e]   = be_r;
    end

    assign rd_tag  = tag_v[rd_slot];
    assign rd_data = data_v[rd_slot];
    assign rd_be   = be_v[rd_slot];

endmodule

// File: rtl/wcb_ctrl.sv
// Decides per cycle whether the memory port carries an eviction or the request itself.
module wcb_ctrl
    import wcb_pkg::*;
(
    input  logic   req_valid,
    input  route_e route,
    input  logic   hit_any,
    input  logic   full,
    input  logic   empty,
    input  logic   mem_ready,
    output logic   evict,
    output logic   direct,
    output logic   req_ready,
    output logic   store_wr,
    output logic   pop
);

    logic need_drain;
    logic is_uc;

    always_comb begin
        is_uc      = (route == RT_UC_READ) || (route == RT_UC_WRITE);
        need_drain = is_uc || (route == RT_BARRIER);
        evict      = req_valid && ((need_drain && !empty) ||
                                   (route == RT_COMBINE && !hit_any && full));
        direct     = req_valid && !evict && (is_uc || route == RT_READ_NOW);
        case (route)
            RT_COMBINE, RT_ABSORB: req_ready = !evict;
            RT_BARRIER:            req_ready = empty;
            default:               req_ready = !evict && mem_ready;
        endcase
        store_wr = req_valid && (route == RT_COMBINE) && !evict;
        pop      = evict && mem_ready;
    end

endmodule

// File: rtl/wcomb_buffer.sv
module wcomb_buffer
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WORD_BYTES = DEF_WORD_BYTES,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int ENTRIES    = DEF_ENTRIES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2:0]              req_kind,
    input  logic [1:0]              req_mtype,
    input  logic                    req_nt,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_BYTES*8-1:0] req_wdata,
    input  logic [WORD_BYTES-1:0]   req_be,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [1:0]              mem_cmd,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_be,
    output logic                    busy,
    output logic                    drain_done
);

    localparam int WORD_W = WORD_BYTES * 8;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(WORD_BYTES);
    localparam int WSEL_W = OFF_W - BSEL_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int PTR_W  = $clog2(ENTRIES);

    typedef struct packed {
        mcmd_e                 cmd;
        logic [ADDR_W-1:0]     addr;
        logic [LINE_W-1:0]     data;
        logic [LINE_BYTES-1:0] be;
    } beat_t;

    route_e                route;
    logic [TAG_W-1:0]      req_tag;
    logic [WSEL_W-1:0]     req_word;
    logic [LINE_W-1:0]     lane_data;
    logic [LINE_BYTES-1:0] lane_be;
    logic [ENTRIES-1:0]    hit;
    logic                  hit_any;
    logic [PTR_W-1:0]      hit_idx;
    logic [PTR_W-1:0]      head, tail, wr_slot;
    logic                  full, empty;
    logic                  evict, direct, store_wr, pop;
    logic [TAG_W-1:0]      rd_tag;
    logic [LINE_W-1:0]     rd_data;
    logic [LINE_BYTES-1:0] rd_be;
    beat_t                 line_beat, direct_beat, beat;

    always_comb begin
        route     = classify(req_kind, req_mtype, req_nt);
        req_tag   = req_addr[ADDR_W-1:OFF_W];
        req_word  = req_addr[OFF_W-1:BSEL_W];
        lane_data = LINE_W'(req_wdata) << (int'(req_word) * WORD_W);
        lane_be   = LINE_BYTES'(req_be) << (int'(req_word) * WORD_BYTES);
        hit_any   = |hit;
        hit_idx   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit[e]) hit_idx = PTR_W'(e);
        end
        wr_slot = hit_any ? hit_idx : tail;
    end

    wcb_ctrl u_ctrl (
        .req_valid (req_valid),
        .route     (route),
        .hit_any   (hit_any),
        .full      (full),
        .empty     (empty),
        .mem_ready (mem_ready),
        .evict     (evict),
        .direct    (direct),
        .req_ready (req_ready),
        .store_wr  (store_wr),
        .pop       (pop)
    );

    wcb_order #(.ENTRIES(ENTRIES)) u_order (
        .clk   (clk),
        .rst   (rst),
        .push  (store_wr && !hit_any),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .empty (empty)
    );

    wcb_lines #(
        .ENTRIES    (ENTRIES),
        .TAG_W      (TAG_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .lk_tag   (req_tag),
        .hit      (hit),
        .wr_en    (store_wr),
        .wr_alloc (!hit_any),
        .wr_slot  (wr_slot),
        .wr_data  (lane_data),
        .wr_be    (lane_be),
        .clr_en   (pop),
        .clr_slot (head),
        .rd_slot  (head),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_be    (rd_be)
    );

    always_comb begin
        line_beat.cmd    = MC_LINE_WR;
        line_beat.addr   = {rd_tag, {OFF_W{1'b0}}};
        line_beat.data   = rd_data;
        line_beat.be     = rd_be;
        direct_beat.cmd  = (route == RT_UC_WRITE) ? MC_UC_WR : MC_READ;
        direct_beat.addr = req_addr;
        direct_beat.data = (route == RT_UC_WRITE) ? lane_data : '0;
        direct_beat.be   = lane_be;
        beat             = evict ? line_beat : direct_beat;
    end

    assign mem_valid = evict || direct;
    assign mem_cmd   = beat.cmd;
    assign mem_addr  = beat.addr;
    assign mem_wdata = beat.data;
    assign mem_be    = beat.be;
    assign busy      = !empty;

    always_ff @(posedge clk) begin
        if (rst) drain_done <= 1'b0;
        else     drain_done <= req_valid && req_ready && (route == RT_BARRIER);
    end

endmodule

// File: rtl/wcomb_buffer_checker.sv
module wcomb_buffer_checker
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_kind,
    input logic [1:0]        req_mtype,
    input logic              req_nt,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [1:0]        mem_cmd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              drain_done
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    logic acc;
    assign acc = req_valid && req_ready;

    assert_beat_held_R11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_cmd) && $stable(mem_addr));

    assert_fence_empty_R6: assert property (@(posedge clk) disable iff (rst)
        acc && (req_kind == K_SFENCE || req_kind == K_MFENCE) |-> !busy);

    assert_done_empty_R6: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> !busy);

    assert_lock_intr_empty_R7: assert property (@(posedge clk) disable iff (rst)
        acc && (req_kind == K_LOCK || req_kind == K_INTR) |-> !busy);

    assert_uc_write_empty_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_cmd == MC_UC_WR |-> !busy);

    assert_uc_read_empty_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_LOAD && req_mtype == MT_UC &&
        mem_valid && mem_cmd == MC_READ |-> !busy);

    assert_wc_read_direct_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == K_LOAD && req_mtype == MT_WC |->
        mem_valid && mem_cmd == MC_READ);

    assert_wb_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        acc && req_mtype == MT_WB && !req_nt &&
        (req_kind == K_STORE || req_kind == K_LOAD) |-> !mem_valid);

    assert_line_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_cmd == MC_LINE_WR |-> busy && mem_addr[OFF_W-1:0] == '0);

endmodule

bind wcomb_buffer wcomb_buffer_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .req_mtype  (req_mtype),
    .req_nt     (req_nt),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_cmd    (mem_cmd),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .drain_done (drain_done)
);

// File: tb/wcomb_buffer_bench.sv
module wcomb_buffer_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int REGION = 512;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [2:0]   req_kind;
    logic [1:0]   req_mtype;
    logic         req_nt;
    logic [31:0]  req_addr;
    logic [63:0]  req_wdata;
    logic [7:0]   req_be;
    logic         mem_valid;
    logic         mem_ready;
    logic [1:0]   mem_cmd;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic [63:0]  mem_be;
    logic         busy;
    logic         drain_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wcomb_buffer u_wcomb_buffer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_mtype(req_mtype), .req_nt(req_nt), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_cmd(mem_cmd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .busy(busy), .drain_done(drain_done)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_tr  = 0;
    bit rdy_rand = 0;
    bit last_acc;
    bit saw_done;
    bit prev_stall = 0;
    logic [1:0]  prev_cmd;
    logic [31:0] prev_addr;
    logic [1:0]  tr_cmd  [1024];
    logic [31:0] tr_addr [1024];
    logic [63:0] tr_be   [1024];
    logic [7:0]  img     [REGION];
    logic [7:0]  expd    [REGION];

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit in_region(logic [31:0] a);
        return (a >= BASE) && (a < BASE + REGION);
    endfunction

    task automatic tick();
        #1;
        last_acc = req_valid && req_ready;
        if (drain_done) saw_done = 1;
        if (prev_stall)
            chk_eq("R11 offered transfer held", {29'd0, mem_valid, mem_cmd, mem_addr},
                   {29'd0, 1'b1, prev_cmd, prev_addr});
        if (mem_valid && mem_ready) begin
            if (n_tr < 1024) begin
                tr_cmd[n_tr] = mem_cmd; tr_addr[n_tr] = mem_addr; tr_be[n_tr] = mem_be;
            end
            n_tr++;
            if ((mem_cmd == 2'd0 || mem_cmd == 2'd1) && in_region(mem_addr)) begin
                int off = int'((mem_addr - BASE) & ~32'd63);
                for (int b = 0; b < 64; b++)
                    if (mem_be[b]) img[off + b] = mem_wdata[b*8 +: 8];
            end
        end
        prev_stall = mem_valid && !mem_ready;
        prev_cmd   = mem_cmd;
        prev_addr  = mem_addr;
        @(posedge clk);
        @(negedge clk);
        mem_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    endtask

    task automatic do_req(input logic [2:0] k, input logic [1:0] mt, input logic nt,
                          input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
        req_kind = k; req_mtype = mt; req_nt = nt; req_addr = a; req_wdata = d; req_be = be;
        req_valid = 1'b1;
        do tick(); while (!last_acc);
        req_valid = 1'b0;
        if (k == 3'd0 && (nt || mt != 2'd0) && in_region(a)) begin
            int off = int'(a - BASE);
            for (int b = 0; b < 8; b++)
                if (be[b]) expd[off + b] = d[b*8 +: 8];
        end
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) tick();
    endtask

    task automatic cmp_image(input string tag);
        for (int l = 0; l < REGION / 64; l++) begin
            int mism = 0;
            for (int b = 0; b < 64; b++)
                if (img[l*64 + b] !== expd[l*64 + b]) mism++;
            chk_eq(tag, 64'(mism), 64'd0);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int base_tr;
        void'($urandom(32'd1357));
        for (int i = 0; i < REGION; i++) begin img[i] = 8'h00; expd[i] = 8'h00; end
        rst = 1'b1; req_valid = 1'b0; mem_ready = 1'b1;
        req_kind = '0; req_mtype = '0; req_nt = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk_eq("R1 busy after reset", 64'(busy), 64'd0);
        chk_eq("R1 mem_valid idle", 64'(mem_valid), 64'd0);
        chk_eq("R1 drain_done after reset", 64'(drain_done), 64'd0);
        @(negedge clk);

        // R2 merge of two stores into one line, drained by store-fence (R6)
        base_tr = n_tr;
        do_req(3'd0, 2'd1, 1'b0, BASE + 32'h00, 64'h1122_3344_5566_7788, 8'hFF);
        do_req(3'd0, 2'd1, 1'b0, BASE + 32'h18, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
        idle(1);
        chk_eq("R2 no transfer before eviction", 64'(n_tr - base_tr), 64'd0);
        chk_eq("R12 busy with held line", 64'(busy), 64'd1);
        saw_done = 0;
        do_req(3'd2, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        idle(1);
        chk_eq("R2 one line transfer", 64'(n_tr - base_tr), 64'd1);
        chk_eq("R2 merged byte enables", tr_be[base_tr], 64'h0000_0000_0F00_00FF);
        chk_eq("R10 line address", 64'(tr_addr[base_tr]), 64'(BASE));
        chk_eq("R6 fence done pulse", 64'(saw_done), 64'd1);
        chk_eq("R6 empty after fence", 64'(busy), 64'd0);
        cmp_image("R2 memory image after fence");

        // R3 non-temporal store to uncached memory is buffered; R4 WC load bypasses
        base_tr = n_tr;
        do_req(3'd0, 2'd2, 1'b1, BASE + 32'h148, 64'hABAB_ABAB_ABAB_ABAB, 8'hFF);
        idle(1);
        chk_eq("R3 NT store held", 64'(busy), 64'd1);
        chk_eq("R3 NT store no transfer", 64'(n_tr - base_tr), 64'd0);
        do_req(3'd1, 2'd1, 1'b0, BASE + 32'h140, 64'h0, 8'hFF);
        idle(1);
        chk_eq("R4 read issued alone", 64'(n_tr - base_tr), 64'd1);
        chk_eq("R4 read command", 64'(tr_cmd[base_tr]), 64'd2);
        chk_eq("R4 read address", 64'(tr_addr[base_tr]), 64'(BASE + 32'h140));
        chk_eq("R4 entry still held", 64'(busy), 64'd1);
        chk_eq("R4 memory still stale", 64'(img[32'h148]), 64'h00);

        // R5 uncached store drains first, then goes out unmerged
        base_tr = n_tr;
        do_req(3'd0, 2'd2, 1'b0, BASE + 32'h1D0, 64'hCAFE_F00D_1234_5678, 8'h3C);
        idle(1);
        chk_eq("R5 drain plus uncached write", 64'(n_tr - base_tr), 64'd2);
        chk_eq("R5 line write first", 64'(tr_cmd[base_tr]), 64'd0);
        chk_eq("R5 drained line address", 64'(tr_addr[base_tr]), 64'(BASE + 32'h140));
        chk_eq("R5 uncached write second", 64'(tr_cmd[base_tr + 1]), 64'd1);
        chk_eq("R5 uncached address", 64'(tr_addr[base_tr + 1]), 64'(BASE + 32'h1D0));
        chk_eq("R5 uncached lane enables", tr_be[base_tr + 1], 64'h0000_0000_003C_0000);
        chk_eq("R12 empty after uncached", 64'(busy), 64'd0);
        chk_eq("R3 NT data reached memory", 64'(img[32'h148]), 64'hAB);

        // R9 overflow evicts oldest; R7 lock drains rest in order (R10)
        base_tr = n_tr;
        for (int i = 0; i < 5; i++)
            do_req(3'd0, 2'd1, 1'b0, BASE + 32'(64 * i) + 32'h8, 64'(i + 1) * 64'h0101_0101, 8'hF0);
        chk_eq("R9 one eviction on overflow", 64'(n_tr - base_tr), 64'd1);
        chk_eq("R9 oldest evicted", 64'(tr_addr[base_tr]), 64'(BASE));
        saw_done = 0;
        do_req(3'd4, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        idle(1);
        chk_eq("R7 lock drained all", 64'(n_tr - base_tr), 64'd5);
        for (int i = 1; i < 5; i++)
            chk_eq("R10 allocation order", 64'(tr_addr[base_tr + i]), 64'(BASE + 32'(64 * i)));
        chk_eq("R7 lock done pulse", 64'(saw_done), 64'd1);
        chk_eq("R7 empty after lock", 64'(busy), 64'd0);

        // R8 write-back traffic neither transfers nor drains
        do_req(3'd0, 2'd1, 1'b0, BASE + 32'h0, 64'h5A5A_5A5A_5A5A_5A5A, 8'h81);
        base_tr = n_tr;
        do_req(3'd0, 2'd0, 1'b0, BASE + 32'h80, 64'hFFFF, 8'hFF);
        do_req(3'd1, 2'd0, 1'b0, BASE + 32'h80, 64'h0, 8'hFF);
        idle(1);
        chk_eq("R8 no transfer for write-back", 64'(n_tr - base_tr), 64'd0);
        chk_eq("R8 entry kept", 64'(busy), 64'd1);
        saw_done = 0;
        do_req(3'd3, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        idle(1);
        chk_eq("R6 full fence drains", 64'(n_tr - base_tr), 64'd1);
        chk_eq("R6 full fence done", 64'(saw_done), 64'd1);

        // R7 interrupt drain
        base_tr = n_tr;
        do_req(3'd0, 2'd1, 1'b0, BASE + 32'h88, 64'h7777_0000_0000_7777, 8'hC3);
        saw_done = 0;
        do_req(3'd5, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        idle(1);
        chk_eq("R7 interrupt drains", 64'(n_tr - base_tr), 64'd1);
        chk_eq("R7 interrupt done", 64'(saw_done), 64'd1);
        cmp_image("R10 memory image after directed");

        // Random mix under memory-port stalls (R2 R3 R5 R9 R10 R11)
        rdy_rand = 1;
        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom % 20);
            logic [31:0] a = BASE + 32'(($urandom % 8) * 64) + 32'(($urandom % 8) * 8);
            logic [63:0] d = {$urandom, $urandom};
            logic [7:0]  be = 8'($urandom) | 8'h01;
            if (sel < 12)      do_req(3'd0, 2'd1, 1'b0, a, d, be);
            else if (sel < 14) do_req(3'd0, 2'($urandom % 3), 1'b1, a, d, be);
            else if (sel < 16) do_req(3'd1, 2'd1, 1'b0, a, 64'h0, 8'hFF);
            else if (sel < 17) do_req(3'd0, 2'd0, 1'b0, a, d, be);
            else if (sel < 18) do_req(3'd0, 2'd2, 1'b0, a, d, be);
            else if (sel < 19) do_req(3'd1, 2'd2, 1'b0, a, 64'h0, 8'hFF);
            else               do_req(3'd2, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        end
        do_req(3'd3, 2'd0, 1'b0, 32'h0, 64'h0, 8'h0);
        idle(2);
        chk_eq("R12 empty after final fence", 64'(busy), 64'd0);
        cmp_image("R2 memory image after random mix");

        summary();
        $finish;
    end

endmodule